// File: doc/BRIEF.md
# Round-and-Saturate Fixed-Point Requantizer

This block narrows a signed fixed-point word. The input has `IN_W` bits, of which `IN_F` are fractional. The output has `OUT_W` bits, of which `OUT_F` are fractional. Both formats are parameters, with `OUT_F < IN_F` and `OUT_W < IN_W`.

The `IN_F - OUT_F` surplus fraction bits are removed by rounding to the nearest value. A tie moves away from zero in both directions. The sign of the input decides how the rounding carry is formed.

The rounded value is then compared against the output range. A value that does not fit is pinned to the largest positive code or the most negative code, and a flag output reports that clamping took place. The path is purely combinational, so it can sit between any two pipeline stages of a datapath, for example after a multiply-accumulate.

Top module: `fxp_requant`

## Requirements
- R1: When no clamping occurs, the output times 2^(IN_F-OUT_F) differs from the input by at most half an output LSB; the result is the nearest output code.
- R2: For a non-negative input, the rounding carry equals the most significant discarded bit, so a positive tie (discarded bits exactly 100..0) rounds up by one output LSB.
- R3: For a negative input, the rounding carry is the top discarded bit ANDed with the OR of the remaining discarded bits. A negative tie rounds away from zero, and the output never has the opposite sign of the input.
- R4: With exactly one discarded bit, a negative input never receives a carry. With 6Q3 to 4Q2, input code 6'h3F (-0.125) gives 4'hF (-0.25).
- R5: Adding the rounding carry to the largest kept value cannot wrap to a negative number. Input 10'h1FF in the 10Q6 to 6Q3 setup gives 6'h1F.
- R6: A positive result that does not fit produces the code with sign bit 0 and all other bits 1.
- R7: A negative result that does not fit produces the code with sign bit 1 and all other bits 0.
- R8: `sat_flag` is 1 exactly when the output was clamped and 0 otherwise.
- R9: In 6Q3 to 4Q2, input 6'h1F (3.875) gives 4'h7 (1.75), and input 6'h27 (-3.125) gives 4'h8 (-2.0), both with `sat_flag` = 1.
- R10: For every input code, the output and flag equal an integer model that rounds half away from zero and then clamps to [-2^(OUT_W-1), 2^(OUT_W-1)-1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_val | input | IN_W | Signed input word with IN_F fraction bits |
| out_val | output | OUT_W | Signed rounded and clamped word with OUT_F fraction bits |
| sat_flag | output | 1 | High when out_val was clamped to a range limit |

## Verification
The bench builds two instances. The first, `dut`, converts 10Q6 to 6Q3. It discards three bits, so the negative-carry term has two lower bits to OR, and the kept range exceeds the output range on both sides.

The second instance converts 6Q3 to 4Q2. It discards a single bit, which exercises the variant where the negative carry is forced to zero and gives the two clamping examples of R9. Both instances are small enough to be swept through every input code against the integer model, which reaches every state of the sign, carry and overflow terms.

// File: rtl/fxp_requant_pkg.sv
package fxp_requant_pkg;

  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_HI   = 2'd1,
    CLAMP_LO   = 2'd2
  } clamp_e;

endpackage

// File: rtl/fxp_round_carry.sv
module fxp_round_carry #(
  parameter int DROP = 3
) (
  input  logic [DROP-1:0] frac_bits,
  input  logic            neg,
  output logic            carry
);

  generate
    if (DROP == 1) begin : g_single
      // no lower bits: a negative value never takes the carry
      assign carry = frac_bits[0] & ~neg;
    end else begin : g_multi
      logic low_any;
      assign low_any = |frac_bits[DROP-2:0];
      assign carry   = neg ? (frac_bits[DROP-1] & low_any) : frac_bits[DROP-1];
    end
  endgenerate

endmodule

// File: rtl/fxp_round_add.sv
module fxp_round_add #(
  parameter int KEEP = 7
) (
  input  logic [KEEP-1:0] kept,
  input  logic            carry,
  output logic [KEEP:0]   rounded
);

  logic [KEEP:0] ext;

  // one guard bit of sign so the increment cannot wrap
  assign ext     = {kept[KEEP-1], kept};
  assign rounded = ext + {{KEEP{1'b0}}, carry};

endmodule

// File: rtl/fxp_sat_clamp.sv
module fxp_sat_clamp
  import fxp_requant_pkg::*;
#(
  parameter int KEEP  = 7,
  parameter int OUT_W = 6
) (
  input  logic [KEEP:0]    rounded,
  output logic [OUT_W-1:0] out_val,
  output logic             ovf
);

  localparam int HEAD_W = KEEP - OUT_W + 2;

  logic [HEAD_W-1:0] head;
  logic              fits;
  clamp_e            mode;

  assign head = rounded[KEEP:OUT_W-1];
  assign fits = (head == {HEAD_W{1'b0}}) || (head == {HEAD_W{1'b1}});

  always_comb begin
    if (fits)              mode = CLAMP_NONE;
    else if (rounded[KEEP]) mode = CLAMP_LO;
    else                   mode = CLAMP_HI;
  end

  always_comb begin
    case (mode)
      CLAMP_HI: out_val = {1'b0, {(OUT_W-1){1'b1}}};
      CLAMP_LO: out_val = {1'b1, {(OUT_W-1){1'b0}}};
      default:  out_val = rounded[OUT_W-1:0];
    endcase
  end

  assign ovf = (mode != CLAMP_NONE);

endmodule

// File: rtl/fxp_requant.sv
module fxp_requant #(
  parameter int IN_W  = 10,
  parameter int IN_F  = 6,
  parameter int OUT_W = 6,
  parameter int OUT_F = 3
) (
  input  logic [IN_W-1:0]  in_val,
  output logic [OUT_W-1:0] out_val,
  output logic             sat_flag
);

  localparam int DROP = IN_F - OUT_F;
  localparam int KEEP = IN_W - DROP;

  logic            carry;
  logic [KEEP:0]   rounded;

  fxp_round_carry #(.DROP(DROP)) u_carry (
    .frac_bits (in_val[DROP-1:0]),
    .neg       (in_val[IN_W-1]),
    .carry     (carry)
  );

  fxp_round_add #(.KEEP(KEEP)) u_add (
    .kept    (in_val[IN_W-1:DROP]),
    .carry   (carry),
    .rounded (rounded)
  );

  fxp_sat_clamp #(.KEEP(KEEP), .OUT_W(OUT_W)) u_clamp (
    .rounded (rounded),
    .out_val (out_val),
    .ovf     (sat_flag)
  );

endmodule

// File: rtl/fxp_requant_chk.sv
module fxp_requant_chk #(
  parameter int IN_W  = 10,
  parameter int IN_F  = 6,
  parameter int OUT_W = 6,
  parameter int OUT_F = 3
) (
  input logic [IN_W-1:0]  in_val,
  input logic [OUT_W-1:0] out_val,
  input logic             sat_flag
);

  localparam int DROP = IN_F - OUT_F;
  localparam logic signed [63:0] HALF = 64'sd1 <<< (DROP - 1);
  localparam logic signed [63:0] OMAX = (64'sd1 <<< (OUT_W - 1)) - 64'sd1;
  localparam logic signed [63:0] OMIN = -(64'sd1 <<< (OUT_W - 1));

  logic signed [63:0] xi;
  logic signed [63:0] yo;
  logic signed [63:0] ys;

  always_comb begin
    xi = {{(64-IN_W){in_val[IN_W-1]}}, in_val};
    yo = {{(64-OUT_W){out_val[OUT_W-1]}}, out_val};
    ys = yo <<< DROP;
    if (!sat_flag) begin
      p_round_err_r1: assert ((ys - xi <= HALF) && (xi - ys <= HALF))
        else $error("rounding error beyond half LSB");
    end
    p_sign_keep_r3: assert (!(xi >= 0 && yo < 0) && !(xi < 0 && yo > 0))
      else $error("output sign opposes input");
    if (sat_flag) begin
      p_clamp_code_r8: assert (yo == OMAX || yo == OMIN)
        else $error("flag set without limit code");
    end
    if (sat_flag && yo == OMAX) begin
      p_ovf_pos_r6: assert (xi >= (OMAX <<< DROP) + HALF)
        else $error("positive clamp on in-range value");
    end
    if (sat_flag && yo == OMIN) begin
      p_ovf_neg_r7: assert (xi <= (OMIN <<< DROP) - HALF)
        else $error("negative clamp on in-range value");
    end
  end

endmodule

bind fxp_requant fxp_requant_chk #(
  .IN_W(IN_W), .IN_F(IN_F), .OUT_W(OUT_W), .OUT_F(OUT_F)
) u_chk (
  .in_val   (in_val),
  .out_val  (out_val),
  .sat_flag (sat_flag)
);

// File: tb/tb_fxp_requant.sv
`timescale 1ns/1ps
module tb_fxp_requant;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [9:0] a_in = '0;
  logic [5:0] a_out;
  logic       a_flag;
  logic [5:0] b_in = '0;
  logic [3:0] b_out;
  logic       b_flag;

  fxp_requant #(.IN_W(10), .IN_F(6), .OUT_W(6), .OUT_F(3)) dut (
    .in_val(a_in), .out_val(a_out), .sat_flag(a_flag));

  fxp_requant #(.IN_W(6), .IN_F(3), .OUT_W(4), .OUT_F(2)) dut_one (
    .in_val(b_in), .out_val(b_out), .sat_flag(b_flag));

  function automatic longint model_val(longint x, int d, int ow);
    longint h = longint'(1) <<< (d - 1);
    longint r;
    longint mx = (longint'(1) <<< (ow - 1)) - 1;
    longint mn = -(longint'(1) <<< (ow - 1));
    if (x >= 0) r = (x + h) >>> d;
    else        r = -((-x + h) >>> d);
    if (r > mx) r = mx;
    if (r < mn) r = mn;
    return r;
  endfunction

  function automatic bit model_ovf(longint x, int d, int ow);
    longint h = longint'(1) <<< (d - 1);
    longint r;
    if (x >= 0) r = (x + h) >>> d;
    else        r = -((-x + h) >>> d);
    return (r > (longint'(1) <<< (ow - 1)) - 1) || (r < -(longint'(1) <<< (ow - 1)));
  endfunction

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive_a(int v);
    @(negedge clk);
    a_in = 10'(v);
    #1;
  endtask

  task automatic drive_b(int v);
    @(negedge clk);
    b_in = 6'(v);
    #1;
  endtask

  task automatic t_zero();
    drive_a(0);
    chk("R1 zero", longint'($signed(a_out)), 0);
    chk("R8 zero flag", longint'(a_flag), 0);
  endtask

  task automatic t_pos_tie();
    drive_a(4);   chk("R2 tie +0.5", longint'($signed(a_out)), 1);
    drive_a(3);   chk("R2 below tie", longint'($signed(a_out)), 0);
    drive_a(20);  chk("R2 tie +2.5", longint'($signed(a_out)), 3);
  endtask

  task automatic t_neg_carry();
    drive_a(-4);  chk("R3 tie -0.5", longint'($signed(a_out)), -1);
    drive_a(-3);  chk("R3 -0.375", longint'($signed(a_out)), 0);
    drive_a(-5);  chk("R3 -0.625", longint'($signed(a_out)), -1);
    drive_a(-12); chk("R3 tie -1.5", longint'($signed(a_out)), -2);
    drive_a(-11); chk("R3 -1.375", longint'($signed(a_out)), -1);
  endtask

  task automatic t_single_drop();
    drive_b(6'h3F); chk("R4 -0.5 LSB", longint'($signed(b_out)), -1);
    drive_b(-3);    chk("R4 -1.5 LSB", longint'($signed(b_out)), -2);
    drive_b(1);     chk("R4 +0.5 LSB", longint'($signed(b_out)), 1);
  endtask

  task automatic t_no_wrap();
    drive_a(10'h1FF);
    chk("R5 top no wrap", longint'($signed(a_out)), 31);
    chk("R5 top flag", longint'(a_flag), 1);
  endtask

  task automatic t_pos_sat();
    drive_a(252); chk("R6 clamp hi", longint'(a_out), 6'h1F);
    chk("R8 flag hi", longint'(a_flag), 1);
    drive_a(251); chk("R6 edge fits", longint'($signed(a_out)), 31);
    chk("R8 edge flag", longint'(a_flag), 0);
  endtask

  task automatic t_neg_sat();
    drive_a(-260); chk("R7 clamp lo", longint'(a_out), 6'h20);
    chk("R8 flag lo", longint'(a_flag), 1);
    drive_a(-259); chk("R7 edge fits", longint'($signed(a_out)), -32);
    chk("R8 edge lo flag", longint'(a_flag), 0);
    drive_a(-512); chk("R7 most neg", longint'(a_out), 6'h20);
  endtask

  task automatic t_examples();
    drive_b(6'h1F); chk("R9 3.875", longint'(b_out), 4'h7);
    chk("R9 flag pos", longint'(b_flag), 1);
    drive_b(6'h27); chk("R9 -3.125", longint'(b_out), 4'h8);
    chk("R9 flag neg", longint'(b_flag), 1);
  endtask

  task automatic t_sweep();
    for (int i = -512; i < 512; i++) begin
      drive_a(i);
      chk("R10 sweep a", longint'($signed(a_out)), model_val(longint'(i), 3, 6));
      chk("R10 sweep a flag", longint'(a_flag), longint'(model_ovf(longint'(i), 3, 6)));
    end
    for (int i = -32; i < 32; i++) begin
      drive_b(i);
      chk("R10 sweep b", longint'($signed(b_out)), model_val(longint'(i), 1, 4));
      chk("R10 sweep b flag", longint'(b_flag), longint'(model_ovf(longint'(i), 1, 4)));
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog got %0d expected %0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_zero();
    t_pos_tie();
    t_neg_carry();
    t_single_drop();
    t_no_wrap();
    t_pos_sat();
    t_neg_sat();
    t_examples();
    t_sweep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule